// File: doc/BRIEF.md
# Per-Port Statistics Counter Bank

This block keeps the event statistics of a small multi-port switch. Every cycle it takes one strobe per tracked event for each of the four switch ports, such as bytes by priority, frame size buckets, error classes, collisions and pause frames. Each strobe adds one to a dedicated counter. A second, smaller group of counters records frames dropped on transmit and on receive, for each of the four ports and for the internal host port.

A processor reads any counter by putting its index on a simple read port for one cycle. The reply word appears on the next cycle. Per-port counters are cleared by the read that returns them, so software samples them at its own pace and accumulates the totals. The reply also flags a wrap and shows whether the counter has ever counted. Drop counters keep their value across reads and stop at their ceiling.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset every counter, overflow flag and valid flag is zero, `rd_valid_o` is 0 and `rd_data_o` is 0.
- R2: Per-port counter `c` (0..31) of port `p` (0..3) sits at index `p*32 + c`. Its reply word holds the count in bits 29:0, zero-extended from `CNT_W` bits. Bit 30 is the valid flag and bit 31 is the overflow flag. Strobe `evt_i[p*32 + c]` feeds it.
- R3: Each cycle with a strobe high adds exactly one to that counter. Other counters are not affected.
- R4: A cycle with `rd_en_i` high captures `rd_idx_i`. On the following cycle `rd_valid_o` is 1 and `rd_data_o` holds the addressed word as it stood before that edge. Otherwise `rd_valid_o` is 0.
- R5: Reading a per-port counter sets its count to zero and clears its overflow flag.
- R6: A strobe in the same cycle as a clearing read of the same counter is kept. The reply excludes it and the counter continues from 1.
- R7: When a counter at its all-ones value receives a strobe, it wraps to 0 and sets its overflow flag. The flag stays set until a read clears it.
- R8: The valid flag rises with the first strobe after reset and reads do not clear it. A counter that has never counted replies with valid 0.
- R9: Drop counters sit at index 0x100 + k. For k = 0..3 they count `tx_drop_i[k]` of ports 0..3, and k = 4 counts `tx_drop_i[4]` of the internal port. For k = 5..9 they count `rx_drop_i[k-5]` in the same port order. The reply is the 16-bit value zero-extended to 32 bits.
- R10: Reading a drop counter does not change its value.
- R11: A drop counter stops at 0xFFFF and stays there on further strobes.
- R12: An index that maps to no counter (0x80..0xFF, 0x10A and above) replies with 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 128 | One strobe per per-port counter, index p*32+c |
| tx_drop_i | input | 5 | Transmit drop strobes, ports 0..3 then internal port |
| rx_drop_i | input | 5 | Receive drop strobes, ports 0..3 then internal port |
| rd_en_i | input | 1 | Read request, one cycle per read |
| rd_idx_i | input | 9 | Counter index of the read |
| rd_valid_o | output | 1 | Reply valid, one cycle after the request |
| rd_data_o | output | 32 | Reply word |

## Verification
Two things can hit one counter in the same cycle: the clearing read and a new strobe. The bench raises the strobe in the very cycle the read request is presented. It then expects the reply to carry the old count, and a second read to return exactly 1 with the valid flag set. A wrap and its overflow flag are produced with a narrow count width, then cleared by a read. The bench checks that the flag survives until that read and is gone after it.

// File: rtl/stat_pkg.sv
package stat_pkg;
   localparam int WORD_W      = 32;
   localparam int CNT_FIELD_W = 30;

   // reply word: overflow on top, valid below it, count in the low field
   function automatic logic [WORD_W-1:0] pack_word(input logic                   ovf,
                                                   input logic                   vld,
                                                   input logic [CNT_FIELD_W-1:0] cnt);
      return {ovf, vld, cnt};
   endfunction
endpackage

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell #(
   parameter int CNT_W = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             vld_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         if (clr_i) begin
            cnt_q <= {{(CNT_W-1){1'b0}}, evt_i};
            ovf_q <= 1'b0;
         end else if (evt_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
         end
         if (evt_i) vld_q <= 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;
   assign vld_o = vld_q;

   // R3
   inc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R7
   wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i && !clr_i && cnt_q == CNT_MAX) |=> (ovf_q && cnt_q == '0));
   // R5
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> (cnt_q == '0 && !ovf_q));
   // R6
   clear_keep_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && evt_i) |=> (cnt_q == CNT_W'(1) && vld_q && !ovf_q));
   // R8
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> vld_q);
endmodule

// File: rtl/stat_drop_cell.sv
module stat_drop_cell #(
   parameter int DROP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   output logic [DROP_W-1:0] val_o
);
   localparam logic [DROP_W-1:0] DROP_MAX = '1;

   logic [DROP_W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                          val_q <= '0;
      else if (evt_i && val_q != DROP_MAX) val_q <= val_q + 1'b1;
   end

   assign val_o = val_q;

   // R11
   drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q == DROP_MAX) |=> (val_q == DROP_MAX));
   // R10
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_i |=> $stable(val_q));
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
   import stat_pkg::*;
#(
   parameter int NUM_PORTS    = 4,
   parameter int CTR_PER_PORT = 32,
   parameter int CNT_W        = 30,
   parameter int DROP_W       = 16,
   parameter int IDX_W        = 9,
   parameter int DROP_BASE    = 256
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_PORTS*CTR_PER_PORT-1:0] evt_i,
   input  logic [NUM_PORTS:0]                tx_drop_i,
   input  logic [NUM_PORTS:0]                rx_drop_i,
   input  logic                              rd_en_i,
   input  logic [IDX_W-1:0]                  rd_idx_i,
   output logic                              rd_valid_o,
   output logic [WORD_W-1:0]                 rd_data_o
);
   localparam int NUM_CTRS  = NUM_PORTS * CTR_PER_PORT;
   localparam int NUM_SRC   = NUM_PORTS + 1;
   localparam int NUM_DROPS = 2 * NUM_SRC;

   // elaboration-time parameter checks
   if (CNT_W < 1 || CNT_W > CNT_FIELD_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 1..30");
   end
   if (DROP_W < 1 || DROP_W > WORD_W) begin : g_bad_drop_w
      $error("DROP_W must lie in 1..32");
   end
   if (NUM_CTRS > DROP_BASE) begin : g_bad_base
      $error("per-port region overlaps drop region");
   end
   if (DROP_BASE + NUM_DROPS > (1 << IDX_W)) begin : g_bad_idx_w
      $error("IDX_W too narrow for drop region");
   end

   logic [NUM_CTRS-1:0]  ctr_hit;
   logic [NUM_DROPS-1:0] drop_hit;
   logic [NUM_DROPS-1:0] drop_evt;
   logic [WORD_W-1:0]    ctr_word  [NUM_CTRS];
   logic [WORD_W-1:0]    drop_word [NUM_DROPS];
   logic [WORD_W-1:0]    rd_word;

   assign drop_evt = {rx_drop_i, tx_drop_i};

   for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
      logic [CNT_W-1:0] cnt;
      logic             ovf;
      logic             vld;
      assign ctr_hit[i] = (rd_idx_i == IDX_W'(i));
      stat_ctr_cell #(.CNT_W(CNT_W)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .evt_i (evt_i[i]),
         .clr_i (rd_en_i && ctr_hit[i]),
         .cnt_o (cnt),
         .ovf_o (ovf),
         .vld_o (vld)
      );
      assign ctr_word[i] = pack_word(ovf, vld, CNT_FIELD_W'(cnt));
   end

   for (genvar k = 0; k < NUM_DROPS; k++) begin : g_drop
      logic [DROP_W-1:0] val;
      assign drop_hit[k] = (rd_idx_i == IDX_W'(DROP_BASE + k));
      stat_drop_cell #(.DROP_W(DROP_W)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .evt_i (drop_evt[k]),
         .val_o (val)
      );
      assign drop_word[k] = WORD_W'(val);
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_CTRS; i++)
         rd_word = rd_word | (ctr_hit[i] ? ctr_word[i] : '0);
      for (int k = 0; k < NUM_DROPS; k++)
         rd_word = rd_word | (drop_hit[k] ? drop_word[k] : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= rd_en_i;
         if (rd_en_i) rd_data_o <= rd_word;
      end
   end

   // R4
   reply_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i |=> rd_valid_o);
   // R4
   no_stray_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> !rd_valid_o);
   // R12
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !(|ctr_hit) && !(|drop_hit)) |=> (rd_data_o == '0));
   // R2
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctr_hit, drop_hit}));
endmodule

// File: tb/stat_counter_bank_tb.sv
module stat_counter_bank_tb;
   localparam int NC  = 128;
   localparam int BCW = 8;
   localparam int NDR = 10;
   localparam int CMAX = (1 << BCW) - 1;
   localparam int DMAX = 65535;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] evt = '0;
   logic [NDR-1:0] dv = '0;
   logic          rd_en = 1'b0;
   logic [8:0]    rd_idx = '0;
   logic          rd_valid;
   logic [31:0]   rd_data;

   always #4 clk = ~clk;

   stat_counter_bank #(.CNT_W(BCW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .tx_drop_i  (dv[4:0]),
      .rx_drop_i  (dv[9:5]),
      .rd_en_i    (rd_en),
      .rd_idx_i   (rd_idx),
      .rd_valid_o (rd_valid),
      .rd_data_o  (rd_data)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   int unsigned m_cnt [NC];
   bit          m_ovf [NC];
   bit          m_vld [NC];
   int unsigned m_drop[NDR];

   logic [31:0] exp_q[$];
   string       tag_q[$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int idx);
      if (idx < NC)
         return {m_ovf[idx], m_vld[idx], 30'(m_cnt[idx])};
      else if (idx >= 256 && idx < 256 + NDR)
         return 32'(m_drop[idx-256]);
      return 32'h0;
   endfunction

   // strobe one per-port counter for n cycles (gap: idle cycle between)
   task automatic ev(input int k, input int n, input bit gap = 1'b0);
      for (int i = 0; i < n; i++) begin
         evt[k] = 1'b1;
         @(negedge clk);
         evt[k] = 1'b0;
         if (gap) @(negedge clk);
         m_vld[k] = 1'b1;
         if (m_cnt[k] == CMAX) begin
            m_cnt[k] = 0;
            m_ovf[k] = 1'b1;
         end else m_cnt[k]++;
      end
   endtask

   task automatic dev(input int k, input int n);
      for (int i = 0; i < n; i++) begin
         dv[k] = 1'b1;
         @(negedge clk);
         if (m_drop[k] != DMAX) m_drop[k]++;
      end
      dv[k] = 1'b0;
   endtask

   // driver: push expected reply, issue read (optionally with same-cycle strobe)
   task automatic rd(input int idx, input string tag, input bit with_evt = 1'b0);
      exp_q.push_back(exp_word(idx));
      tag_q.push_back(tag);
      rd_en  = 1'b1;
      rd_idx = 9'(idx);
      if (with_evt) evt[idx] = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      evt   = '0;
      if (idx < NC) begin
         m_ovf[idx] = 1'b0;
         m_cnt[idx] = with_evt ? 1 : 0;
         if (with_evt) m_vld[idx] = 1'b1;
      end
   endtask

   // monitor: pop and compare each reply
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) check("R4 unexpected reply", 32'h1, 32'h0);
         else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   initial begin
      #(8 * 180000);
      if (!finished) begin
         finished = 1'b1;
         bad++;
         $display("FAIL watchdog R4 actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset rd_valid", 32'(rd_valid), 32'h0);
      check("R1 reset rd_data", rd_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(5, "R1 counter zero after reset");
      rd(258, "R1 drop zero after reset");

      // basic counting and layout
      ev(3, 5);
      rd(3, "R3 count five");
      rd(3, "R5 cleared, R8 valid kept");
      ev(71, 2);
      ev(127, 4, 1'b1);
      rd(71, "R2 port2 ctr7");
      rd(127, "R2 port3 ctr31 gapped R3");
      ev(64, 1);
      rd(64, "R3 neighbour unaffected");

      // read and strobe in the same cycle
      ev(10, 7);
      rd(10, "R6 reply excludes same-cycle event", 1'b1);
      rd(10, "R6 counter restarted at 1");

      // wrap and overflow
      ev(21, CMAX);
      rd(21, "R7 all ones without overflow");
      ev(20, CMAX + 3);
      rd(20, "R7 wrapped with overflow");
      rd(20, "R7 overflow cleared by read");

      // never-counted counter
      rd(50, "R8 valid low before any event");

      // unmapped index
      ev(40, 3);
      rd(168, "R12 hole returns zero");
      rd(266, "R12 past drop region returns zero");
      rd(40, "R12 counter untouched by hole read");

      // drop counters
      dev(0, 4);
      dev(4, 2);
      dev(9, 6);
      dev(6, 1);
      rd(256, "R9 tx drop port0");
      rd(260, "R9 tx drop internal");
      rd(265, "R9 rx drop internal");
      rd(262, "R9 rx drop port1");
      rd(256, "R10 drop kept after read");

      // saturation
      dev(3, DMAX + 5);
      rd(259, "R11 drop saturated");
      dev(3, 2);
      rd(259, "R11 drop stays saturated");

      repeat (3) @(negedge clk);
      check("R4 all replies seen", 32'(exp_q.size()), 32'h0);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule